// File: doc/BRIEF.md
# Strobe-Referenced Fine Trim Calibrator

This block tunes a local oscillator against a slow, accurate reference strobe, for example a start-of-frame pulse that arrives once per millisecond. With calibration enabled, it counts local clock ticks from one strobe to the next. Eight programmable, non-decreasing thresholds sort each count into one of nine buckets. Each bucket carries a programmable operation, and that operation steers a 5-bit fine trim code toward the nominal tick count. The nominal count is the local clock frequency divided by 1000.

A slow clock gives a short count, and its buckets pull the code down. A fast clock gives a long count, and its buckets push the code up. The code never wraps. If a correction would move it past either end of its range, the code holds and a sticky underrun or overflow flag is set. Software takes the matching interrupt and moves the coarse trim of the oscillator by one step. The oscillator and the coarse trim register are outside this block.

Top module: `sof_trim_cal`

## Requirements
- R1: After reset the fine code is 16 (half range) and the binary step is 16. Both flags and both interrupt lines are 0, the interrupt enables are 0, and thresholds and operations hold their defaults.
- R2: While `cal_en` is 1, the measurement is the number of clock cycles between two consecutive sampled strobes. The first strobe after `cal_en` rises only starts counting and applies no update.
- R3: The tick counter saturates at all ones when strobes stop. A saturated count falls into the top bucket.
- R4: The bucket index is the number of thresholds that are less than or equal to the count, giving 0 to 8. The defaults are 70 %, 80 % and 90 % of nominal, nominal minus 1250 ppm, nominal, nominal plus 1250 ppm, 110 % and 120 %. Threshold k is written through `thr_we`/`thr_idx`/`thr_wdata`.
- R5: Operation word bits [1:0] select the operation: 0 none, 1 binary step, 2 add one, 3 subtract one. Bit 4 gives the binary step direction, 1 down and 0 up. The default words for buckets 0 to 8 are 00, 11, 11, 13, 00, 00, 12, 01, 01 (hex). Bucket k is written through `op_we`/`op_idx`/`op_wdata`.
- R6: A binary step moves the code by the current step, clamped to the range 0 to 31. The step then halves, but never goes below 1. Dropping `cal_en` returns the step to 16.
- R7: Add raises the code by one. Subtract lowers it by one.
- R8: A downward correction at code 0 holds the code and sets the underrun flag. An upward correction at code 31 holds the code and sets the overflow flag.
- R9: `irq_under` is the underrun flag ANDed with enable bit 3. `irq_over` is the overflow flag ANDed with enable bit 2. Writing 1 to bit 3 or bit 2 of `clr_wdata` clears that flag. A new event in the same cycle wins over the clear.
- R10: With `stop_on_nop` set, a measurement that lands in a no-op bucket freezes all later updates. The freeze lasts until `cal_en` drops.
- R11: The code changes only on the clock edge that samples an armed strobe and is visible the following cycle. Strobes sampled while `cal_en` is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock being measured |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_en | input | 1 | Calibration enable; low disarms and resets the step |
| stop_on_nop | input | 1 | Freeze after a no-op bucket |
| sof | input | 1 | Reference strobe, one cycle wide, synchronous |
| thr_we | input | 1 | Threshold write strobe |
| thr_idx | input | 3 | Threshold index |
| thr_wdata | input | CNT_W | Threshold value |
| op_we | input | 1 | Operation write strobe |
| op_idx | input | 4 | Bucket index (9 to 15 ignored) |
| op_wdata | input | 5 | Operation word |
| ien_we | input | 1 | Interrupt enable write strobe |
| ien_wdata | input | 4 | Bit 3 underrun enable, bit 2 overflow enable |
| clr_we | input | 1 | Flag clear strobe |
| clr_wdata | input | 4 | Write 1 to bit 3 / bit 2 to clear underrun / overflow |
| fine_trim | output | 5 | Fine trim code |
| sts_under | output | 1 | Sticky underrun flag |
| sts_over | output | 1 | Sticky overflow flag |
| irq_under | output | 1 | Underrun interrupt |
| irq_over | output | 1 | Overflow interrupt |

## Verification
The bench drives the code onto both rails. A design that wraps at a rail instead of holding would show 31 after an underrun or 0 after an overflow, and would miss the flag. It also lets a binary step overshoot the top, which tests clamping, and checks that the step stops at 1 and returns to 16 after a disable. A design that kept the old step would land on 9 instead of 24. It starves the counter past its limit, where a wrapping counter would pick a low bucket. It also covers the arming strobe, a strobe while disabled, and the no-op freeze, any of which would otherwise change the code by one.

// File: rtl/sof_cal_pkg.sv
package sof_cal_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_BIN  = 2'd1,
      OP_INC  = 2'd2,
      OP_DEC  = 2'd3
   } trim_op_e;

   localparam int OPW_W   = 5;
   localparam int DIR_BIT = 4;

   // Reset threshold k; a fixed nine-bucket profile or an even spread
   function automatic int dflt_thr(int nominal, int ppm, int nthr, int k);
      int band;
      band = (nominal * ppm) / 1000000;
      if (nthr == 8) begin
         case (k)
            0: return (nominal * 70) / 100;
            1: return (nominal * 80) / 100;
            2: return (nominal * 90) / 100;
            3: return nominal - band;
            4: return nominal;
            5: return nominal + band;
            6: return (nominal * 110) / 100;
            default: return (nominal * 120) / 100;
         endcase
      end
      return nominal / 2 + (nominal * (k + 1)) / (nthr + 1);
   endfunction

   // Reset operation word for bucket k
   function automatic logic [OPW_W-1:0] dflt_op(int nbkt, int k);
      if (nbkt != 9) return '0;
      case (k)
         1, 2:    return 5'h11;
         3:       return 5'h13;
         6:       return 5'h12;
         7, 8:    return 5'h01;
         default: return 5'h00;
      endcase
   endfunction

endpackage

// File: rtl/sof_tick_meter.sv
module sof_tick_meter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cal_en,
   input  logic             sof,
   output logic             meas_valid,
   output logic [CNT_W-1:0] meas_cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (!cal_en) begin
         armed_q <= 1'b0;
      end else if (sof) begin
         armed_q <= 1'b1;
         cnt_q   <= CNT_ONE;
      end else if (armed_q && cnt_q != CNT_MAX) begin
         cnt_q   <= cnt_q + CNT_ONE;
      end
   end

   assign meas_valid = cal_en & sof & armed_q;
   assign meas_cnt   = cnt_q;

   AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_en && armed_q && !sof && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R3
   AST_STROBE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_en && sof) |=> (cnt_q == CNT_ONE && armed_q)); // R2
   AST_DISABLE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      !cal_en |=> !armed_q); // R11
endmodule

// File: rtl/sof_bucket_sorter.sv
module sof_bucket_sorter #(
   parameter int CNT_W    = 16,
   parameter int NUM_THR  = 8,
   parameter int NOMINAL  = 24000,
   parameter int PPM_BAND = 1250,
   localparam int IDX_W   = $clog2(NUM_THR),
   localparam int BKT_W   = $clog2(NUM_THR + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             thr_we,
   input  logic [IDX_W-1:0] thr_idx,
   input  logic [CNT_W-1:0] thr_wdata,
   input  logic [CNT_W-1:0] meas_cnt,
   output logic [BKT_W-1:0] bucket
);
   import sof_cal_pkg::*;

   logic [CNT_W-1:0]   thr_q [NUM_THR];
   logic [NUM_THR-1:0] at_or_above;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_THR; i++)
            thr_q[i] <= CNT_W'(dflt_thr(NOMINAL, PPM_BAND, NUM_THR, i));
      end else if (thr_we && int'(thr_idx) < NUM_THR) begin
         thr_q[thr_idx] <= thr_wdata;
      end
   end

   for (genvar g = 0; g < NUM_THR; g++) begin : g_cmp
      assign at_or_above[g] = (meas_cnt >= thr_q[g]);
   end

   always_comb begin
      bucket = '0;
      for (int i = 0; i < NUM_THR; i++)
         bucket = bucket + {{(BKT_W-1){1'b0}}, at_or_above[i]};
   end

   AST_SAT_TOP_BUCKET: assert property (@(posedge clk) disable iff (!rst_n)
      (&meas_cnt) |-> (int'(bucket) == NUM_THR)); // R3
endmodule

// File: rtl/sof_trim_engine.sv
module sof_trim_engine #(
   parameter int TRIM_W  = 5,
   parameter int NUM_BKT = 9,
   localparam int BKT_W  = $clog2(NUM_BKT),
   localparam int OIDX_W = (BKT_W < 4) ? 4 : BKT_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cal_en,
   input  logic                           stop_on_nop,
   input  logic                           upd,
   input  logic [BKT_W-1:0]               bucket,
   input  logic                           op_we,
   input  logic [OIDX_W-1:0]              op_idx,
   input  logic [sof_cal_pkg::OPW_W-1:0]  op_wdata,
   input  logic                           ien_we,
   input  logic [3:0]                     ien_wdata,
   input  logic                           clr_we,
   input  logic [3:0]                     clr_wdata,
   output logic [TRIM_W-1:0]              trim,
   output logic                           sts_under,
   output logic                           sts_over,
   output logic                           irq_under,
   output logic                           irq_over
);
   import sof_cal_pkg::*;

   localparam logic [TRIM_W-1:0] T_MAX  = '1;
   localparam logic [TRIM_W-1:0] T_ONE  = TRIM_W'(1);
   localparam logic [TRIM_W-1:0] STEP0  = T_ONE << (TRIM_W - 1);

   logic [OPW_W-1:0]  op_q [NUM_BKT];
   logic [TRIM_W-1:0] trim_q, trim_d, step_q, step_d;
   logic              halt_q, halt_d, under_q, over_q, set_u, set_o;
   logic [1:0]        ien_q;
   logic [OPW_W-1:0]  op_sel;
   trim_op_e          op_code;
   logic              go_down;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_BKT; i++) op_q[i] <= dflt_op(NUM_BKT, i);
      end else if (op_we && int'(op_idx) < NUM_BKT) begin
         op_q[op_idx] <= op_wdata;
      end
   end

   assign op_sel  = op_q[bucket];
   assign op_code = trim_op_e'(op_sel[1:0]);
   assign go_down = op_sel[DIR_BIT];

   always_comb begin
      trim_d = trim_q;
      step_d = step_q;
      halt_d = halt_q;
      set_u  = 1'b0;
      set_o  = 1'b0;
      if (!cal_en) begin
         step_d = STEP0;
         halt_d = 1'b0;
      end else if (upd && !halt_q) begin
         case (op_code)
            OP_NONE: if (stop_on_nop) halt_d = 1'b1;
            OP_BIN: begin
               step_d = (step_q > T_ONE) ? (step_q >> 1) : T_ONE;
               if (go_down) begin
                  if (trim_q == '0)          set_u  = 1'b1;
                  else if (trim_q <= step_q) trim_d = '0;
                  else                       trim_d = trim_q - step_q;
               end else begin
                  if (trim_q == T_MAX)                set_o  = 1'b1;
                  else if (T_MAX - trim_q <= step_q)  trim_d = T_MAX;
                  else                                trim_d = trim_q + step_q;
               end
            end
            OP_INC: if (trim_q == T_MAX) set_o = 1'b1; else trim_d = trim_q + T_ONE;
            OP_DEC: if (trim_q == '0)    set_u = 1'b1; else trim_d = trim_q - T_ONE;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trim_q  <= STEP0;
         step_q  <= STEP0;
         halt_q  <= 1'b0;
         under_q <= 1'b0;
         over_q  <= 1'b0;
         ien_q   <= 2'b00;
      end else begin
         trim_q  <= trim_d;
         step_q  <= step_d;
         halt_q  <= halt_d;
         under_q <= (under_q & ~(clr_we & clr_wdata[3])) | set_u;
         over_q  <= (over_q  & ~(clr_we & clr_wdata[2])) | set_o;
         if (ien_we) ien_q <= ien_wdata[3:2];
      end
   end

   assign trim      = trim_q;
   assign sts_under = under_q;
   assign sts_over  = over_q;
   assign irq_under = under_q & ien_q[1];
   assign irq_over  = over_q  & ien_q[0];

   AST_TRIM_ONLY_ON_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd && cal_en) |=> (trim_q == $past(trim_q))); // R11
   AST_UNDER_AT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(under_q) |-> (trim_q == '0)); // R8
   AST_OVER_AT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(over_q) |-> (trim_q == T_MAX)); // R8
   AST_STEP_POW2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(step_q) == 1); // R6
   AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && cal_en) |=> $stable(trim_q)); // R10
endmodule

// File: rtl/sof_trim_cal.sv
module sof_trim_cal #(
   parameter int CNT_W    = 16,
   parameter int NUM_THR  = 8,
   parameter int TRIM_W   = 5,
   parameter int NOMINAL  = 24000,
   parameter int PPM_BAND = 1250,
   localparam int IDX_W   = $clog2(NUM_THR),
   localparam int NUM_BKT = NUM_THR + 1,
   localparam int BKT_W   = $clog2(NUM_BKT),
   localparam int OIDX_W  = (BKT_W < 4) ? 4 : BKT_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cal_en,
   input  logic                          stop_on_nop,
   input  logic                          sof,
   input  logic                          thr_we,
   input  logic [IDX_W-1:0]              thr_idx,
   input  logic [CNT_W-1:0]              thr_wdata,
   input  logic                          op_we,
   input  logic [OIDX_W-1:0]             op_idx,
   input  logic [sof_cal_pkg::OPW_W-1:0] op_wdata,
   input  logic                          ien_we,
   input  logic [3:0]                    ien_wdata,
   input  logic                          clr_we,
   input  logic [3:0]                    clr_wdata,
   output logic [TRIM_W-1:0]             fine_trim,
   output logic                          sts_under,
   output logic                          sts_over,
   output logic                          irq_under,
   output logic                          irq_over
);
   if (TRIM_W < 2) begin : g_bad_trim
      $error("TRIM_W must be at least 2");
   end
   if (NUM_THR < 2) begin : g_bad_thr
      $error("NUM_THR must be at least 2");
   end
   if (CNT_W > 30 || (NOMINAL * 12) / 10 > (1 << CNT_W) - 1) begin : g_bad_cnt
      $error("CNT_W too narrow for the top default threshold");
   end

   logic             meas_valid;
   logic [CNT_W-1:0] meas_cnt;
   logic [BKT_W-1:0] bucket;

   sof_tick_meter #(.CNT_W(CNT_W)) u_meter (
      .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .sof(sof),
      .meas_valid(meas_valid), .meas_cnt(meas_cnt)
   );

   sof_bucket_sorter #(
      .CNT_W(CNT_W), .NUM_THR(NUM_THR), .NOMINAL(NOMINAL), .PPM_BAND(PPM_BAND)
   ) u_sorter (
      .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_idx(thr_idx),
      .thr_wdata(thr_wdata), .meas_cnt(meas_cnt), .bucket(bucket)
   );

   sof_trim_engine #(.TRIM_W(TRIM_W), .NUM_BKT(NUM_BKT)) u_engine (
      .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .stop_on_nop(stop_on_nop),
      .upd(meas_valid), .bucket(bucket),
      .op_we(op_we), .op_idx(op_idx), .op_wdata(op_wdata),
      .ien_we(ien_we), .ien_wdata(ien_wdata),
      .clr_we(clr_we), .clr_wdata(clr_wdata),
      .trim(fine_trim), .sts_under(sts_under), .sts_over(sts_over),
      .irq_under(irq_under), .irq_over(irq_over)
   );
endmodule

// File: tb/tb_sof_trim_cal.sv
`timescale 1ns/1ps
module tb_sof_trim_cal;
   logic       clk = 1'b0;
   logic       rst_n, cal_en, stop_on_nop, sof;
   logic       thr_we, op_we, ien_we, clr_we;
   logic [2:0] thr_idx;
   logic [7:0] thr_wdata;
   logic [3:0] op_idx, ien_wdata, clr_wdata;
   logic [4:0] op_wdata, fine_trim;
   logic       sts_under, sts_over, irq_under, irq_over;

   int    checks = 0, fails = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   always #2 clk = ~clk;

   sof_trim_cal #(.CNT_W(8), .NOMINAL(100)) dut (
      .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .stop_on_nop(stop_on_nop),
      .sof(sof), .thr_we(thr_we), .thr_idx(thr_idx), .thr_wdata(thr_wdata),
      .op_we(op_we), .op_idx(op_idx), .op_wdata(op_wdata),
      .ien_we(ien_we), .ien_wdata(ien_wdata), .clr_we(clr_we),
      .clr_wdata(clr_wdata), .fine_trim(fine_trim), .sts_under(sts_under),
      .sts_over(sts_over), .irq_under(irq_under), .irq_over(irq_over)
   );

   // Behavioural reference model
   int m_thr [8];
   int m_op  [9];
   int m_trim, m_step, m_cnt, m_ien;
   bit m_armed, m_halt, m_under, m_over;

   task automatic m_apply(int cnt, output bit su, output bit so);
      int k = 0;
      int w;
      su = 0; so = 0;
      foreach (m_thr[i]) if (cnt >= m_thr[i]) k++;
      w = m_op[k];
      case (w % 4)
         0: if (stop_on_nop) m_halt = 1;
         1: begin
            if (w / 16 % 2 == 1) begin
               if (m_trim == 0) su = 1;
               else m_trim = (m_trim > m_step) ? m_trim - m_step : 0;
            end else begin
               if (m_trim == 31) so = 1;
               else m_trim = (m_trim + m_step > 31) ? 31 : m_trim + m_step;
            end
            m_step = (m_step > 1) ? m_step / 2 : 1;
         end
         2: if (m_trim == 31) so = 1; else m_trim++;
         default: if (m_trim == 0) su = 1; else m_trim--;
      endcase
   endtask

   always @(posedge clk) begin
      bit su, so;
      su = 0; so = 0;
      if (!rst_n) begin
         m_thr = '{70, 80, 90, 100, 100, 100, 110, 120};
         m_op  = '{'h00, 'h11, 'h11, 'h13, 'h00, 'h00, 'h12, 'h01, 'h01};
         m_trim = 16; m_step = 16; m_cnt = 0; m_ien = 0;
         m_armed = 0; m_halt = 0; m_under = 0; m_over = 0;
      end else begin
         if (!cal_en) begin
            m_armed = 0; m_halt = 0; m_step = 16;
         end else if (sof) begin
            if (m_armed && !m_halt) m_apply(m_cnt, su, so);
            m_armed = 1; m_cnt = 1;
         end else if (m_armed && m_cnt < 255) m_cnt++;
         m_under = (m_under && !(clr_we && clr_wdata[3])) || su;
         m_over  = (m_over  && !(clr_we && clr_wdata[2])) || so;
         if (thr_we) m_thr[thr_idx] = int'(thr_wdata);
         if (op_we && op_idx < 9) m_op[op_idx] = int'(op_wdata);
         if (ien_we) m_ien = int'(ien_wdata);
      end
   end

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         check(fine_trim == 5'(m_trim), cur_req, "model trim", int'(fine_trim), m_trim);
         check(sts_under == m_under && sts_over == m_over, cur_req, "model flags",
               int'({sts_under, sts_over}), int'({m_under, m_over}));
         check(irq_under == (m_under && m_ien / 8 % 2 == 1) &&
               irq_over == (m_over && m_ien / 4 % 2 == 1), cur_req, "model irqs",
               int'({irq_under, irq_over}), int'({m_under, m_over}));
      end
   end

   task automatic strobe();
      sof = 1'b1;
      @(negedge clk);
      sof = 1'b0;
   endtask

   task automatic gap(int n);
      repeat (n - 1) @(negedge clk);
      strobe();
   endtask

   task automatic wr_op(int idx, int val);
      op_we = 1'b1; op_idx = 4'(idx); op_wdata = 5'(val);
      @(negedge clk);
      op_we = 1'b0;
   endtask

   task automatic wr_thr(int idx, int val);
      thr_we = 1'b1; thr_idx = 3'(idx); thr_wdata = 8'(val);
      @(negedge clk);
      thr_we = 1'b0;
   endtask

   task automatic wr_ien(int val);
      ien_we = 1'b1; ien_wdata = 4'(val);
      @(negedge clk);
      ien_we = 1'b0;
   endtask

   task automatic clr(int val);
      clr_we = 1'b1; clr_wdata = 4'(val);
      @(negedge clk);
      clr_we = 1'b0;
   endtask

   task automatic expect_trim(string req, int exp);
      check(fine_trim == 5'(exp), req, "fine_trim", int'(fine_trim), exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cal_en = 1'b0; stop_on_nop = 1'b0; sof = 1'b0;
      thr_we = 1'b0; op_we = 1'b0; ien_we = 1'b0; clr_we = 1'b0;
      thr_idx = '0; thr_wdata = '0; op_idx = '0; op_wdata = '0;
      ien_wdata = '0; clr_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      expect_trim("R1", 16);
      check(!sts_under && !sts_over && !irq_under && !irq_over, "R1", "flags",
            int'({sts_under, sts_over, irq_under, irq_over}), 0);

      wr_ien(4'hC);
      cur_req = "R2"; cal_en = 1'b1;
      strobe();              expect_trim("R2", 16);
      cur_req = "R6";
      gap(85);               expect_trim("R6", 0);
      cur_req = "R8";
      gap(85);               expect_trim("R8", 0);
      check(sts_under && irq_under, "R8", "underrun", int'({sts_under, irq_under}), 3);
      cur_req = "R6";
      gap(130);              expect_trim("R6", 4);
      cur_req = "R7";
      gap(105);              expect_trim("R7", 5);
      gap(95);               expect_trim("R7", 4);
      cur_req = "R6";
      gap(115);              expect_trim("R6", 6);
      gap(115);              expect_trim("R6", 7);
      cur_req = "R9";
      clr(4'h8);
      check(!sts_under && !irq_under, "R9", "clear", int'({sts_under, irq_under}), 0);
      cur_req = "R5";
      gap(50);               expect_trim("R5", 7);
      cur_req = "R3";
      gap(300);              expect_trim("R3", 8);

      cur_req = "R11"; cal_en = 1'b0;
      repeat (3) @(negedge clk);
      strobe();              expect_trim("R11", 8);
      cur_req = "R2"; cal_en = 1'b1;
      strobe();              expect_trim("R2", 8);
      cur_req = "R6";
      gap(130);              expect_trim("R6", 24);
      gap(130);              expect_trim("R6", 31);
      cur_req = "R8";
      gap(130);              expect_trim("R8", 31);
      check(sts_over && irq_over, "R8", "overflow", int'({sts_over, irq_over}), 3);
      cur_req = "R9";
      wr_ien(0);
      check(sts_over && !irq_over, "R9", "masked irq", int'({sts_over, irq_over}), 2);

      cur_req = "R5";
      wr_op(1, 'h03);
      gap(75);               expect_trim("R5", 30);
      cur_req = "R4";
      wr_thr(0, 80);
      gap(75);               expect_trim("R4", 30);

      cur_req = "R10"; stop_on_nop = 1'b1;
      gap(50);               expect_trim("R10", 30);
      gap(95);               expect_trim("R10", 30);
      cal_en = 1'b0;
      @(negedge clk);
      cal_en = 1'b1;
      strobe();
      gap(95);               expect_trim("R10", 29);

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule